// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Pin Takeover

This block is an 8-bit bidirectional I/O port. Software sees two registers over a simple single-cycle bus: an output-value latch and a direction register. Each bit drives one tri-state pad through three signals: output value, output enable and sampled input. When neither of the two on-chip peripherals needs a pin, the port works as plain GPIO. A pin drives its latched value when its direction bit is 1 and floats when the bit is 0.

An SPI unit and a two-channel timer can take pins over. The decision is made from their own control bits. The SPI data-return line is taken while the SPI is on. The SPI select line is taken while the SPI is on, except when it is a master with fault detection off; while taken, that line is always an input. A timer channel pin is taken while its 2-bit edge/level mode field is nonzero. On a taken pin the direction bit no longer controls the pad, but it still chooses what a data read returns: the latch, or the synchronized pin level.

Pin levels pass through a two-flop synchronizer. The synchronized levels feed read-back and are also given to the peripherals.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset the direction register reads 0x00, the latch is 0x00, and every pad output enable is low while no peripheral owns a pin.
- R2: A write with `reg_we` high updates the latch at address 0 and the direction register at address 1 on the next rising edge. A read at address 1 returns the direction register.
- R3: A pin owned by no peripheral has pad enable equal to its direction bit and pad output equal to its latch bit.
- R4: A read at address 0 returns, for each bit whose direction bit is 0, the pad level from two rising edges earlier. The same synchronized value appears on `pin_sync`.
- R5: Bit 5 (SPI data-return line) is owned whenever `spi_en` is 1. Its pad enable and value then follow `spi_miso_oe` and `spi_miso_out`, and its direction bit has no effect on the pad.
- R6: Bit 4 (SPI select line) is owned when `spi_en` is 1 and not (`spi_master` is 1 and `spi_fault_en` is 0). While owned, its pad enable is 0 and its pad output is 0, whatever its direction bit holds.
- R7: Timer channel 0 uses bit 2 and is controlled by `tmr_mode[1:0]`. Channel 1 uses bit 3 and is controlled by `tmr_mode[3:2]`. A channel owns its pin when its field is nonzero. Its pad enable and value then follow `tmr_oe[k]` and `tmr_out[k]`. Field 00 releases the pin to GPIO.
- R8: For each bit, a read at address 0 returns the latch bit when the direction bit is 1, even while a peripheral owns the pin.
- R9: A latch write updates the latch while a peripheral owns the pin. The pin drives the written value as soon as it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Register address: 0 latch, 1 direction |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| spi_en | input | 1 | SPI enabled |
| spi_master | input | 1 | SPI in master mode |
| spi_fault_en | input | 1 | SPI mode-fault detection enabled |
| spi_miso_oe | input | 1 | SPI drive enable for data-return line |
| spi_miso_out | input | 1 | SPI value for data-return line |
| tmr_mode | input | 4 | Timer edge/level fields, channel 1 in [3:2] |
| tmr_oe | input | 2 | Timer channel drive enables |
| tmr_out | input | 2 | Timer channel output values |
| pad_in | input | 8 | Pad levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pin_sync | output | 8 | Synchronized pad levels for peripherals |

## Verification
The hardest case to reach is a pin that a peripheral owns while its direction bit disagrees with the pad state the peripheral chose. The direction bit must then be ignored by the pad but still obeyed by read-back. The stimulus gets there by writing the direction and latch registers first and then switching on peripheral modes under them. This includes the SPI master setting with fault detection on, where the select line turns into a forced input. The bench then reads back with the pad level held opposite to the latch. A second case writes the latch while a pin is owned and then releases the pin, so the first driven value shows whether the write was kept.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Select line is taken unless SPI is off or it is a master ignoring faults
  function automatic logic ss_taken(input logic en, input logic master,
                                    input logic fault_en);
    return en && !(master && !fault_en);
  endfunction

  // A timer channel takes its pin for any nonzero edge/level field
  function automatic logic tch_taken(input logic [1:0] mode);
    return mode != 2'b00;
  endfunction

  // Read-back source: latch when direction is output, pin level otherwise
  function automatic logic rb_pick(input logic dir, input logic lat,
                                   input logic pin);
    return dir ? lat : pin;
  endfunction

endpackage

// File: rtl/gpio_owner_decode.sv
module gpio_owner_decode #(
  parameter int WIDTH    = 8,
  parameter int MISO_BIT = 5,
  parameter int SS_BIT   = 4,
  parameter int TMR_BASE = 2,
  parameter int TMR_CH   = 2
) (
  input  logic                  spi_en,
  input  logic                  spi_master,
  input  logic                  spi_fault_en,
  input  logic                  spi_miso_oe,
  input  logic                  spi_miso_out,
  input  logic [2*TMR_CH-1:0]   tmr_mode,
  input  logic [TMR_CH-1:0]     tmr_oe,
  input  logic [TMR_CH-1:0]     tmr_out,
  output logic [WIDTH-1:0]      own,
  output logic [WIDTH-1:0]      per_oe,
  output logic [WIDTH-1:0]      per_out
);
  import gpio_port_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == MISO_BIT) begin : g_miso
      assign own[i]     = spi_en;
      assign per_oe[i]  = spi_miso_oe;
      assign per_out[i] = spi_miso_out;
    end else if (i == SS_BIT) begin : g_ss
      assign own[i]     = ss_taken(spi_en, spi_master, spi_fault_en);
      assign per_oe[i]  = 1'b0;
      assign per_out[i] = 1'b0;
    end else if (i >= TMR_BASE && i < TMR_BASE + TMR_CH) begin : g_tch
      localparam int K = i - TMR_BASE;
      assign own[i]     = tch_taken(tmr_mode[2*K+1:2*K]);
      assign per_oe[i]  = tmr_oe[K];
      assign per_out[i] = tmr_out[K];
    end else begin : g_free
      assign own[i]     = 1'b0;
      assign per_oe[i]  = 1'b0;
      assign per_out[i] = 1'b0;
    end
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int WIDTH    = 8,
  parameter int ADDR_W   = 1,
  parameter int DATA_OFS = 0,
  parameter int DIR_OFS  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [WIDTH-1:0]  reg_wdata,
  output logic [WIDTH-1:0]  latch_q,
  output logic [WIDTH-1:0]  dir_q
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_OFS);

  logic wr_data, wr_dir;
  assign wr_data = reg_we && (reg_addr == A_DATA);
  assign wr_dir  = reg_we && (reg_addr == A_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      if (wr_data) latch_q <= reg_wdata;
      if (wr_dir)  dir_q   <= reg_wdata;
    end
  end

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(reg_wdata));

  assert_latch_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> latch_q == $past(reg_wdata));

  assert_regs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(latch_q) && $stable(dir_q));

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int CW = $clog2(STAGES + 1);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];

  // cycles since reset, saturating, so the latency check starts clean
  logic [CW-1:0] warm_q;
  logic          warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (!warm)          warm_q <= warm_q + 1'b1;
  end
  assign warm = (warm_q == CW'(STAGES));

  if (STAGES == 2) begin : g_chk2
    assert_sync_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> dout == $past(din, 2));
  end

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
  parameter int WIDTH    = 8,
  parameter int ADDR_W   = 1,
  parameter int SYNC_STG = 2,
  parameter int MISO_BIT = 5,
  parameter int SS_BIT   = 4,
  parameter int TMR_BASE = 2,
  parameter int TMR_CH   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic [WIDTH-1:0]    reg_wdata,
  output logic [WIDTH-1:0]    reg_rdata,
  input  logic                spi_en,
  input  logic                spi_master,
  input  logic                spi_fault_en,
  input  logic                spi_miso_oe,
  input  logic                spi_miso_out,
  input  logic [2*TMR_CH-1:0] tmr_mode,
  input  logic [TMR_CH-1:0]   tmr_oe,
  input  logic [TMR_CH-1:0]   tmr_out,
  input  logic [WIDTH-1:0]    pad_in,
  output logic [WIDTH-1:0]    pad_out,
  output logic [WIDTH-1:0]    pad_oe,
  output logic [WIDTH-1:0]    pin_sync
);
  import gpio_port_pkg::*;

  localparam int                DIR_OFS = 1;
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(DIR_OFS);

  logic [WIDTH-1:0] latch_q, dir_q;
  logic [WIDTH-1:0] own, per_oe, per_out;
  logic [WIDTH-1:0] data_view;

  gpio_port_regs #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_OFS(0), .DIR_OFS(DIR_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .latch_q(latch_q), .dir_q(dir_q)
  );

  gpio_owner_decode #(
    .WIDTH(WIDTH), .MISO_BIT(MISO_BIT), .SS_BIT(SS_BIT),
    .TMR_BASE(TMR_BASE), .TMR_CH(TMR_CH)
  ) u_own (
    .spi_en(spi_en), .spi_master(spi_master), .spi_fault_en(spi_fault_en),
    .spi_miso_oe(spi_miso_oe), .spi_miso_out(spi_miso_out),
    .tmr_mode(tmr_mode), .tmr_oe(tmr_oe), .tmr_out(tmr_out),
    .own(own), .per_oe(per_oe), .per_out(per_out)
  );

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_sync)
  );

  // per-pin pad and read-back muxing
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pad_oe[i]    = own[i] ? per_oe[i]  : dir_q[i];
    assign pad_out[i]   = own[i] ? per_out[i] : latch_q[i];
    assign data_view[i] = rb_pick(dir_q[i], latch_q[i], pin_sync[i]);

    assert_free_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !own[i] |-> (pad_oe[i] == dir_q[i]) && (pad_out[i] == latch_q[i]));

    assert_rb_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_q[i] && reg_addr != A_DIR) |-> reg_rdata[i] == latch_q[i]);
  end

  assign reg_rdata = (reg_addr == A_DIR) ? dir_q : data_view;

  assert_miso_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spi_en |-> (pad_oe[MISO_BIT] == spi_miso_oe) &&
               (pad_out[MISO_BIT] == spi_miso_out));

  assert_ss_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !(spi_master && !spi_fault_en)) |-> !pad_oe[SS_BIT]);

  for (genvar k = 0; k < TMR_CH; k++) begin : g_tchk
    assert_tch_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_mode[2*k+1:2*k] != 2'b00) |->
        (pad_oe[TMR_BASE+k] == tmr_oe[k]) && (pad_out[TMR_BASE+k] == tmr_out[k]));
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> dir_q == '0);

endmodule

// File: tb/test_gpio_mux_port.sv
`timescale 1ns/1ps
module test_gpio_mux_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [0:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       spi_en = 0, spi_master = 0, spi_fault_en = 0;
  logic       spi_miso_oe = 0, spi_miso_out = 0;
  logic [3:0] tmr_mode = '0;
  logic [1:0] tmr_oe = '0, tmr_out = '0;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe, pin_sync;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  gpio_mux_port i_gpio_mux_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_en(spi_en),
    .spi_master(spi_master), .spi_fault_en(spi_fault_en),
    .spi_miso_oe(spi_miso_oe), .spi_miso_out(spi_miso_out),
    .tmr_mode(tmr_mode), .tmr_oe(tmr_oe), .tmr_out(tmr_out),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pin_sync(pin_sync)
  );

  always #2 clk = ~clk;   // 250 MHz

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog: act=%0d expected<=%0d cycles", cycles, 20000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // vector table: {spi_en,master,fault_en}, {miso_oe,miso_out}, tmr_mode,
  // {tmr_oe,tmr_out}, ddr, latch -> expected pad_oe, pad_out
  localparam int NV = 9;
  localparam logic [2:0] V_SPI [NV] = '{3'b000,3'b000,3'b100,3'b110,3'b111,3'b000,3'b000,3'b000,3'b011};
  localparam logic [1:0] V_MIS [NV] = '{2'b00,2'b00,2'b10,2'b01,2'b11,2'b00,2'b00,2'b00,2'b10};
  localparam logic [3:0] V_MOD [NV] = '{4'h0,4'h0,4'h0,4'h0,4'h0,4'b0001,4'b1000,4'b1111,4'h0};
  localparam logic [3:0] V_TMR [NV] = '{4'h0,4'h0,4'h0,4'h0,4'h0,4'b0111,4'b0010,4'b1101,4'h0};
  localparam logic [7:0] V_DDR [NV] = '{8'hFF,8'h0F,8'hFF,8'h30,8'h00,8'h08,8'hFF,8'h00,8'h00};
  localparam logic [7:0] V_LAT [NV] = '{8'hA5,8'h3C,8'hFF,8'h10,8'h00,8'h00,8'h00,8'hFF,8'h00};
  localparam logic [7:0] E_OE  [NV] = '{8'hFF,8'h0F,8'hEF,8'h10,8'h20,8'h0C,8'hF7,8'h0C,8'h00};
  localparam logic [7:0] E_OUT [NV] = '{8'hA5,8'h3C,8'hCF,8'h30,8'h20,8'h04,8'h08,8'hF7,8'h00};

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reg_addr = 1'b1; #0.5;
    check("R1 dir reset", reg_rdata, 8'h00);
    check("R1 oe reset", pad_oe, 8'h00);
    check("R1 out reset", pad_out, 8'h00);
    reg_addr = 1'b0; #0.5;
    check("R1 data read reset", reg_rdata, 8'h00);

    // table walk: R2 R3 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      wr(1'b1, V_DDR[v]);
      wr(1'b0, V_LAT[v]);
      {spi_en, spi_master, spi_fault_en} = V_SPI[v];
      {spi_miso_oe, spi_miso_out} = V_MIS[v];
      tmr_mode = V_MOD[v];
      {tmr_oe, tmr_out} = V_TMR[v];
      reg_addr = 1'b1;
      #1;
      check($sformatf("R2 dir readback v%0d", v), reg_rdata, V_DDR[v]);
      check($sformatf("R3/R5/R6/R7 pad_oe v%0d", v), pad_oe, E_OE[v]);
      check($sformatf("R3/R5/R6/R7 pad_out v%0d", v), pad_out, E_OUT[v]);
    end
    spi_en = 0; spi_master = 0; spi_fault_en = 0; tmr_mode = '0;
    spi_miso_oe = 0; spi_miso_out = 0; tmr_oe = '0; tmr_out = '0;

    // R4 two-edge synchronizer latency
    wr(1'b1, 8'h00);
    reg_addr = 1'b0;
    @(negedge clk);
    pad_in = 8'h5A;
    @(negedge clk);
    check("R4 one edge old", reg_rdata, 8'h00);
    @(negedge clk);
    check("R4 two edges new", reg_rdata, 8'h5A);
    check("R4 pin_sync", pin_sync, 8'h5A);

    // R8 read source while SPI owns bit 5 and SS bit 4
    spi_en = 1; spi_master = 0; spi_miso_oe = 0;
    pad_in = 8'h00;
    wr(1'b0, 8'h30);
    wr(1'b1, 8'h30);
    repeat (2) @(negedge clk);
    reg_addr = 1'b0; #0.5;
    check("R8 owned read latch", reg_rdata, 8'h30);
    check("R6 ss input despite dir", pad_oe & 8'h10, 8'h00);
    wr(1'b1, 8'h00);
    pad_in = 8'h20;
    repeat (2) @(negedge clk);
    reg_addr = 1'b0; #0.5;
    check("R8 owned read pin", reg_rdata, 8'h20);

    // R9 latch write while owned, then release
    wr(1'b1, 8'h20);
    spi_miso_oe = 1; spi_miso_out = 0;
    wr(1'b0, 8'h20);
    #0.5;
    check("R9 owned pad follows SPI", pad_out & 8'h20, 8'h00);
    spi_en = 0; #0.5;
    check("R9 released shows latch", pad_out & 8'h20, 8'h20);
    check("R9 released oe from dir", pad_oe, 8'h20);

    // R6 master with fault detect on keeps select owned
    wr(1'b1, 8'h10);
    spi_en = 1; spi_master = 1; spi_fault_en = 1; #0.5;
    check("R6 master fault_en owns ss", pad_oe & 8'h10, 8'h00);
    spi_fault_en = 0; #0.5;
    check("R6 master no fault releases ss", pad_oe & 8'h10, 8'h10);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule